// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a received byte stream, already framed by start and end markers, and lays each frame down in memory. The memory is a set of fixed-size buffers listed by a circular ring of descriptors. A descriptor is two 32-bit words at 8-byte spacing. The word at offset +0 holds the buffer address and two flag bits. The word at offset +4 holds the status the engine reports.

For each buffer it fills, the engine first writes the status word and then writes the address word back with the ownership flag set. A frame longer than one buffer carries on in the next descriptor. The descriptor whose wrap flag is set is the last in the ring, and the engine returns to the ring base after it. Software gives a buffer back by clearing its ownership flag.

If the engine needs a descriptor that software still owns, it discards the rest of the frame and pulses a buffer-unavailable output. Software programs the ring base while reception is disabled. The buffer size is selected as 64 bytes shifted left by a small code.

Top module: `rx_ring_writer`

## Requirements
- R1: For each buffer, the engine reads the address word at the current ring pointer, with a read latency of one cycle, and writes the buffer's bytes in frame order at consecutive byte addresses. The start address is the address word with its low two bits taken as zero. The ring base is 8-byte aligned, each descriptor takes 8 bytes, the address word is at +0 and the status word at +4.
- R2: When a buffer is finished, the engine writes the status word and, in the next cycle, writes the address word back with bit 0 (used) set. The address and bit 1 of that word keep their fetched values.
- R3: In the status word, bit 14 marks the first buffer of a frame and bit 15 marks the last buffer. Bits 11:0 hold the total frame length in the last buffer and are zero in every other buffer. All other bits are zero.
- R4: A buffer holds 64 << size_code bytes. Once a buffer is full and the frame has not ended, the frame continues in the next descriptor. A frame that ends exactly at a buffer boundary uses no extra buffer.
- R5: A descriptor whose address word has bit 1 (wrap) set is the last in the ring. The descriptor that follows it is the one at the ring base, and a frame may span this wrap.
- R6: If a fetched address word has bit 0 set, bna_pulse is high for exactly one cycle. The rest of the frame is then accepted and discarded, nothing is written to that descriptor, and the next frame tries the same descriptor again.
- R7: While rx_en is low between frames, the ring pointer is held at ring_base and every input byte is accepted and discarded, with no memory writes.
- R8: With reception enabled and no frame in progress, bytes that lack the start marker are accepted and discarded without any memory write.
- R9: During reset, desc_rd, desc_wr, buf_we and bna_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Reception enable, sampled between frames |
| ring_base | input | AW | Byte address of the first descriptor |
| size_code | input | 3 | Buffer size select: 64 << size_code bytes |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte accepted this cycle when in_valid is high |
| desc_rd | output | 1 | Descriptor word read strobe |
| desc_wr | output | 1 | Descriptor word write strobe |
| desc_addr | output | AW | Descriptor word byte address |
| desc_wdata | output | 32 | Descriptor write data |
| desc_rdata | input | 32 | Descriptor read data, one cycle after desc_rd |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | AW | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| bna_pulse | output | 1 | One-cycle pulse: needed descriptor still owned by software |

## Verification
The hardest case to reach is an ownership failure in the middle of a frame: the first buffer of the frame is taken cleanly and the next descriptor is still owned. The bench makes this happen by editing the descriptor memory model between frames. It frees one descriptor, marks the one after it as used, and sends a frame longer than one buffer. It then frees the blocked descriptor and confirms that the next frame lands there. A frame of about 2,950 bytes walks the pointer through the wrap descriptor, so the final buffer of that frame sits at the ring base.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int DW       = 32;
  localparam int SZ_W     = 3;
  localparam int OFF_W    = 6 + (1 << SZ_W) - 1;
  localparam int LEN_W    = 12;
  localparam int USED_BIT = 0;
  localparam int WRAP_BIT = 1;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_DATA, ST_WSTAT, ST_WADDR, ST_DROP
  } rx_state_e;

  // Index of the final byte in a buffer of 64 << code bytes.
  function automatic logic [OFF_W-1:0] last_off(input logic [SZ_W-1:0] code);
    return OFF_W'((32'd64 << code) - 32'd1);
  endfunction

  // Status word written back for one buffer.
  function automatic logic [DW-1:0] status_word(input logic sof, input logic eof,
                                                input logic [LEN_W-1:0] len);
    logic [DW-1:0] w;
    w = '0;
    w[SOF_BIT] = sof;
    w[EOF_BIT] = eof;
    if (eof) w[LEN_W-1:0] = len;
    return w;
  endfunction
endpackage

// File: rtl/rxr_ptr.sv
module rxr_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_base,
  input  logic [AW-1:0] base,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] ptr,
  output logic          adv_wrap
);
  localparam logic [AW-1:0] DESC_STRIDE = AW'(8);

  assign adv_wrap = advance && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)         ptr <= '0;
    else if (load_base) ptr <= base;
    else if (advance)   ptr <= wrap ? base : ptr + DESC_STRIDE;
  end

  // R5
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_wrap |=> (ptr == base));

  // R1
  stride_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap && !load_base) |=> (ptr == $past(ptr) + DESC_STRIDE));
endmodule

// File: rtl/rxr_fill.sv
module rxr_fill
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clr,
  input  logic             buf_clr,
  input  logic             step,
  input  logic [SZ_W-1:0]  size_code,
  output logic [OFF_W-1:0] off,
  output logic [LEN_W-1:0] len,
  output logic             at_end
);
  assign at_end = (off == last_off(size_code));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off <= '0;
      len <= '0;
    end else begin
      if (buf_clr)   off <= '0;
      else if (step) off <= off + 1'b1;
      if (frame_clr) len <= '0;
      else if (step) len <= len + 1'b1;
    end
  end

  // R4
  off_in_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (off <= last_off(size_code)));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic [AW-1:0]   ring_base,
  input  logic [SZ_W-1:0] size_code,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_sof,
  input  logic            in_eof,
  output logic            in_ready,
  output logic            desc_rd,
  output logic            desc_wr,
  output logic [AW-1:0]   desc_addr,
  output logic [DW-1:0]   desc_wdata,
  input  logic [DW-1:0]   desc_rdata,
  output logic            buf_we,
  output logic [AW-1:0]   buf_addr,
  output logic [7:0]      buf_wdata,
  output logic            bna_pulse
);
  localparam logic [AW-1:0] STAT_OFS = AW'(4);

  rx_state_e        st;
  logic             first_buf, last_buf, buf_wrap;
  logic [AW-1:0]    buf_base, ptr;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] len;
  logic             at_end, adv_wrap, take;
  logic             frame_start, buf_done, owned_hit;
  logic [DW-1:0]    addr_word;

  // Named internal events
  assign take        = in_valid && in_ready;
  assign frame_start = (st == ST_IDLE) && rx_en && in_valid && in_sof;
  assign owned_hit   = (st == ST_CHECK) && desc_rdata[USED_BIT];
  assign buf_done    = (st == ST_DATA) && take && (in_eof || at_end);

  rxr_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_base((st == ST_IDLE) && !rx_en),
    .base     (ring_base),
    .advance  (st == ST_WADDR),
    .wrap     (buf_wrap),
    .ptr      (ptr),
    .adv_wrap (adv_wrap)
  );

  rxr_fill u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_clr(frame_start),
    .buf_clr  (st == ST_CHECK),
    .step     ((st == ST_DATA) && take),
    .size_code(size_code),
    .off      (off),
    .len      (len),
    .at_end   (at_end)
  );

  always_comb begin
    addr_word           = DW'(buf_base);
    addr_word[WRAP_BIT] = buf_wrap;
    addr_word[USED_BIT] = 1'b1;
  end

  always_comb begin
    in_ready   = 1'b0;
    desc_rd    = 1'b0;
    desc_wr    = 1'b0;
    desc_addr  = ptr;
    desc_wdata = '0;
    buf_we     = 1'b0;
    case (st)
      ST_IDLE:  in_ready = !rx_en || !in_sof;
      ST_FETCH: desc_rd = 1'b1;
      ST_DATA: begin
        in_ready = 1'b1;
        buf_we   = in_valid;
      end
      ST_WSTAT: begin
        desc_wr    = 1'b1;
        desc_addr  = ptr + STAT_OFS;
        desc_wdata = status_word(first_buf, last_buf, len);
      end
      ST_WADDR: begin
        desc_wr    = 1'b1;
        desc_wdata = addr_word;
      end
      ST_DROP:  in_ready = 1'b1;
      default:  in_ready = 1'b0;
    endcase
  end

  assign buf_addr  = buf_base + AW'(off);
  assign buf_wdata = in_data;
  assign bna_pulse = owned_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      first_buf <= 1'b0;
      last_buf  <= 1'b0;
      buf_wrap  <= 1'b0;
      buf_base  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (frame_start) begin
          st        <= ST_FETCH;
          first_buf <= 1'b1;
        end
        ST_FETCH: st <= ST_CHECK;
        ST_CHECK: begin
          if (owned_hit) st <= ST_DROP;
          else begin
            buf_base <= AW'({desc_rdata[DW-1:2], 2'b00});
            buf_wrap <= desc_rdata[WRAP_BIT];
            st       <= ST_DATA;
          end
        end
        ST_DATA: if (buf_done) begin
          last_buf <= in_eof;
          st       <= ST_WSTAT;
        end
        ST_WSTAT: st <= ST_WADDR;
        ST_WADDR: begin
          first_buf <= 1'b0;
          st        <= last_buf ? ST_IDLE : ST_FETCH;
        end
        ST_DROP: if (take && in_eof) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  stat_then_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr && desc_addr[2]) |=> (desc_wr && !desc_addr[2] && desc_wdata[USED_BIT]));

  // R6
  bna_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bna_pulse |=> (!bna_pulse && !desc_wr && !buf_we));

  // R1
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_rd |=> (!buf_we && !desc_rd));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st == ST_IDLE) && $past(!rx_en)) |-> (!desc_rd && !desc_wr && !buf_we));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!desc_rd && !desc_wr && !buf_we && !bna_pulse));
endmodule

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int BASE = 32'h100;
  localparam int SLOT = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0;
  logic [AW-1:0] ring_base = AW'(BASE);
  logic [2:0] size_code = 3'd1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, desc_rd, desc_wr, buf_we, bna_pulse;
  logic [AW-1:0] desc_addr, buf_addr;
  logic [31:0] desc_wdata, desc_rdata;
  logic [7:0] buf_wdata;

  logic [31:0] dmem [0:63];
  logic [7:0]  bmem [0:4095];
  logic        sw_we = 1'b0;
  int          sw_idx = 0;
  logic [31:0] sw_val = '0;
  int bna_cnt = 0, dwr_cnt = 0, bwe_cnt = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_writer #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .size_code(size_code), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready),
    .desc_rd(desc_rd), .desc_wr(desc_wr), .desc_addr(desc_addr),
    .desc_wdata(desc_wdata), .desc_rdata(desc_rdata), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .bna_pulse(bna_pulse)
  );

  // Memory model: one process owns every write
  always @(posedge clk) begin
    if (desc_rd) desc_rdata <= dmem[(desc_addr - BASE) >> 2];
    if (desc_wr) begin
      dmem[(desc_addr - BASE) >> 2] <= desc_wdata;
      dwr_cnt <= dwr_cnt + 1;
    end
    if (sw_we) dmem[sw_idx] <= sw_val;
    if (buf_we) begin
      bmem[buf_addr[11:0]] <= buf_wdata;
      bwe_cnt <= bwe_cnt + 1;
    end
    if (bna_pulse) bna_cnt <= bna_cnt + 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sw_write(int idx, logic [31:0] val);
    @(negedge clk);
    sw_we = 1'b1; sw_idx = idx; sw_val = val;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic send_bytes(int n, int seed, bit with_sof);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(seed + i);
      in_sof   = with_sof && (i == 0);
      in_eof   = (i == n - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // Compare nbytes of descriptor d's buffer with frame bytes from position pos
  task automatic chk_buf(string req, int d, int pos, int nbytes, int seed);
    int bad = 0;
    for (int j = 0; j < nbytes; j++)
      if (bmem[d*SLOT + j] !== 8'(seed + pos + j)) bad++;
    chk(req, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 desc_rd", desc_rd, 0);
    chk("R9 desc_wr", desc_wr, 0);
    chk("R9 buf_we", buf_we, 0);
    chk("R9 bna_pulse", bna_pulse, 0);
  endtask

  task automatic t_single();
    send_bytes(10, 8'h10, 1);
    chk("R2 desc0 addr word", dmem[0], 32'h001);
    chk("R3 desc0 status", dmem[1], 32'hC00A);
    chk_buf("R1 desc0 data", 0, 0, 10, 8'h10);
  endtask

  task automatic t_multi();
    send_bytes(300, 8'h33, 1);
    chk("R3 desc1 status", dmem[3], 32'h4000);
    chk("R2 desc2 addr word", dmem[4], 32'h101);
    chk("R3 desc2 status", dmem[5], 32'h0000);
    chk("R3 desc3 status", dmem[7], 32'h812C);
    chk_buf("R4 desc1 data", 1, 0, 128, 8'h33);
    chk_buf("R4 desc2 data", 2, 128, 128, 8'h33);
    chk_buf("R4 desc3 data", 3, 256, 44, 8'h33);
  endtask

  task automatic t_exact();
    send_bytes(128, 8'h51, 1);
    chk("R4 exact desc4 status", dmem[9], 32'hC080);
    chk("R4 exact desc4 addr", dmem[8], 32'h201);
    chk("R4 exact desc5 untouched", dmem[10], 32'h280);
  endtask

  task automatic t_small();
    size_code = 3'd0;
    send_bytes(100, 8'h72, 1);
    chk("R4 64B desc5 status", dmem[11], 32'h4000);
    chk("R4 64B desc6 status", dmem[13], 32'h8064);
    chk_buf("R4 64B desc5 data", 5, 0, 64, 8'h72);
    chk_buf("R4 64B desc6 data", 6, 64, 36, 8'h72);
    size_code = 3'd1;
  endtask

  task automatic t_bna();
    int b0;
    sw_write(14, 32'h381);
    b0 = bna_cnt;
    send_bytes(50, 8'h90, 1);
    chk("R6 pulse at frame start", bna_cnt, b0 + 1);
    chk("R6 desc7 status untouched", dmem[15], 32'h0);
    chk("R6 desc7 addr untouched", dmem[14], 32'h381);
    sw_write(14, 32'h380);
    sw_write(16, 32'h401);
    send_bytes(200, 8'hA0, 1);
    chk("R6 pulse mid frame", bna_cnt, b0 + 2);
    chk("R6 desc7 first part", dmem[15], 32'h4000);
    chk("R6 desc7 used", dmem[14], 32'h381);
    chk("R6 desc8 status untouched", dmem[17], 32'h0);
    sw_write(16, 32'h400);
    send_bytes(20, 8'hB7, 1);
    chk("R6 retry lands in desc8", dmem[17], 32'hC014);
    chk_buf("R6 retry data", 8, 0, 20, 8'hB7);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 32; i++)
      sw_write(2*i, (i*SLOT) | ((i == 31) ? 32'h2 : 32'h0));
    send_bytes(23*128 + 10, 8'h05, 1);
    chk("R5 desc9 status", dmem[19], 32'h4000);
    chk("R5 desc31 addr keeps wrap", dmem[62], 32'hF83);
    chk("R5 desc31 status", dmem[63], 32'h0000);
    chk("R5 desc0 after wrap", dmem[1], 32'h8B8A);
    chk_buf("R5 desc31 data", 31, 22*128, 128, 8'h05);
    chk_buf("R5 desc0 data", 0, 23*128, 10, 8'h05);
  endtask

  task automatic t_disable();
    int w0, b0;
    sw_write(0, 32'h000);
    w0 = dwr_cnt; b0 = bwe_cnt;
    send_bytes(3, 8'h44, 0);
    chk("R8 stray desc writes", dwr_cnt, w0);
    chk("R8 stray buf writes", bwe_cnt, b0);
    @(negedge clk);
    rx_en = 1'b0;
    send_bytes(30, 8'h61, 1);
    chk("R7 disabled desc writes", dwr_cnt, w0);
    chk("R7 disabled buf writes", bwe_cnt, b0);
    @(negedge clk);
    rx_en = 1'b1;
    send_bytes(5, 8'hC3, 1);
    chk("R7 pointer back at base", dmem[1], 32'hC005);
    chk_buf("R7 data at base", 0, 0, 5, 8'hC3);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) bmem[i] = 8'h00;
    desc_rdata = '0;
    for (int i = 0; i < 32; i++)
      sw_write(2*i, (i*SLOT) | ((i == 31) ? 32'h2 : 32'h0));
    for (int i = 0; i < 32; i++) sw_write(2*i + 1, 32'h0);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rx_en = 1'b1;
    t_single();
    t_multi();
    t_exact();
    t_small();
    t_bna();
    t_wrap();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule